// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the 12-bit instruction fetch address for a small 4-bit processor. The address is kept in two parts: a one-bit page register in the top bit, and an 11-bit counting section below it. The counting section steps forward once per instruction. The page bit only changes when a full 12-bit address is loaded. The decoder, the program ROM and the return-address stack are outside the block. It receives their commands and data on its ports.

Six commands are accepted. Increment steps the counting section. Jump and call load a complete 12-bit target. Return loads an address popped from the stack. Table branch jumps inside the current 256-word block: it keeps the upper four address bits and uses an 8-bit index formed from the internal 4-bit table register and the 4-bit accumulator value. Return-constant is a return that also splits a fetched ROM byte. The high nibble goes into the table register, and the low nibble is written back to the accumulator through a one-cycle write strobe.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `pc_out`, `tbr_out`, `acc_we` and `acc_wdata` to zero, whatever the command inputs are.
- R2: Increment alone changes `pc_out[10:0]` to its previous value plus one, and leaves `pc_out[11]` unchanged.
- R3: Increment from a count of 0x7FF wraps the count to 0x000 and keeps the page bit, so 0x7FF goes to 0x000 and 0xFFF goes to 0x800.
- R4: Jump or call loads all 12 bits of `load_addr` into the address, page bit included.
- R5: Table branch loads `{pc_out[11:8], tbr_out, acc_in}`. Bits 7..4 of the new address are the table register and bits 3..0 are the accumulator input.
- R6: Plain return loads `ret_addr` into all 12 address bits and leaves the table register unchanged.
- R7: Return-constant loads `ret_addr` and sets the table register to `rom_data[7:4]`. In the following cycle it drives `acc_we` high with `acc_wdata` equal to `rom_data[3:0]`.
- R8: When several commands are active in one cycle, they are ranked from highest to lowest as: reset, return (plain or constant), table branch, jump/call, increment.
- R9: With no command active, the address and the table register hold their values.
- R10: `acc_we` is high only in the cycle after a return-constant that was accepted. In every other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_en | input | 1 | Step the counting section |
| jump_en | input | 1 | Load `load_addr` (jump) |
| call_en | input | 1 | Load `load_addr` (call target) |
| ret_en | input | 1 | Load `ret_addr` |
| tjmp_en | input | 1 | Table branch within the current 256-word block |
| rtnw_en | input | 1 | Return-constant: load `ret_addr` and split `rom_data` |
| load_addr | input | 12 | Jump or call target |
| ret_addr | input | 12 | Address popped from the stack |
| rom_data | input | 8 | ROM byte for return-constant |
| acc_in | input | 4 | Current accumulator value |
| pc_out | output | 12 | Program address |
| tbr_out | output | 4 | Table register |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 4 | Accumulator write data |

## Verification
Directed sequences step the address across both 0x7FF and 0xFFF, and tell a count wrap that keeps the page apart from one that carries into the page. Table branches are run from addresses whose low byte differs from the index being loaded, which shows whether the upper nibble is kept and the low byte replaced. Return-constant uses bytes whose two nibbles differ, so swapped nibbles or a strobe in the wrong cycle show up. Random cycles enable several commands at once, which exercises the priority ranking against a reference model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_INC  = 3'd1,
        OP_LOAD = 3'd2,
        OP_TBL  = 3'd3,
        OP_RET  = 3'd4,
        OP_RETK = 3'd5
    } pc_op_e;
endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic   inc_en,
    input  logic   jump_en,
    input  logic   call_en,
    input  logic   ret_en,
    input  logic   tjmp_en,
    input  logic   rtnw_en,
    output pc_op_e op
);
    always_comb begin
        if (rtnw_en)                op = OP_RETK;
        else if (ret_en)            op = OP_RET;
        else if (tjmp_en)           op = OP_TBL;
        else if (jump_en | call_en) op = OP_LOAD;
        else if (inc_en)            op = OP_INC;
        else                        op = OP_HOLD;
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int NIB_W = 4,
    localparam int ADDR_W = CNT_W + 1,
    localparam int IDX_W  = 2 * NIB_W,
    localparam int UP_W   = ADDR_W - IDX_W
) (
    input  pc_op_e            op,
    input  logic              page_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [NIB_W-1:0]  tbr_q,
    input  logic [NIB_W-1:0]  acc_in,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic              page_d,
    output logic [CNT_W-1:0]  cnt_d
);
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] tbl_addr;

    assign cur_addr = {page_q, cnt_q};
    assign tbl_addr = {cur_addr[ADDR_W-1 -: UP_W], tbr_q, acc_in};

    always_comb begin
        page_d = page_q;
        cnt_d  = cnt_q;
        unique case (op)
            OP_INC:  cnt_d = cnt_q + CNT_W'(1);
            OP_LOAD: {page_d, cnt_d} = load_addr;
            OP_TBL:  {page_d, cnt_d} = tbl_addr;
            OP_RET,
            OP_RETK: {page_d, cnt_d} = ret_addr;
            default: ;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int NIB_W = 4,
    localparam int ADDR_W = CNT_W + 1,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              jump_en,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic              tjmp_en,
    input  logic              rtnw_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [BYTE_W-1:0] rom_data,
    input  logic [NIB_W-1:0]  acc_in,
    output logic [ADDR_W-1:0] pc_out,
    output logic [NIB_W-1:0]  tbr_out,
    output logic              acc_we,
    output logic [NIB_W-1:0]  acc_wdata
);
    typedef struct packed {
        logic             page;
        logic [CNT_W-1:0] cnt;
        logic [NIB_W-1:0] tbr;
        logic             we;
        logic [NIB_W-1:0] wd;
    } seq_state_t;

    seq_state_t st_d, st_q;
    pc_op_e     op;
    logic             page_nx;
    logic [CNT_W-1:0] cnt_nx;

    pcseq_arbiter u_arb (
        .inc_en  (inc_en),
        .jump_en (jump_en),
        .call_en (call_en),
        .ret_en  (ret_en),
        .tjmp_en (tjmp_en),
        .rtnw_en (rtnw_en),
        .op      (op)
    );

    pcseq_target #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_tgt (
        .op        (op),
        .page_q    (st_q.page),
        .cnt_q     (st_q.cnt),
        .tbr_q     (st_q.tbr),
        .acc_in    (acc_in),
        .load_addr (load_addr),
        .ret_addr  (ret_addr),
        .page_d    (page_nx),
        .cnt_d     (cnt_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.page = page_nx;
        st_d.cnt  = cnt_nx;
        st_d.we   = 1'b0;
        st_d.wd   = '0;
        if (op == OP_RETK) begin
            st_d.tbr = rom_data[BYTE_W-1:NIB_W];
            st_d.we  = 1'b1;
            st_d.wd  = rom_data[NIB_W-1:0];
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_out    = {st_q.page, st_q.cnt};
    assign tbr_out   = st_q.tbr;
    assign acc_we    = st_q.we;
    assign acc_wdata = st_q.wd;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int ADDR_W = 12,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              inc_en,
    input logic              jump_en,
    input logic              call_en,
    input logic              ret_en,
    input logic              tjmp_en,
    input logic              rtnw_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic [ADDR_W-1:0] ret_addr,
    input logic [2*NIB_W-1:0] rom_data,
    input logic [NIB_W-1:0]  acc_in,
    input logic [ADDR_W-1:0] pc_out,
    input logic [NIB_W-1:0]  tbr_out,
    input logic              acc_we,
    input logic [NIB_W-1:0]  acc_wdata
);
    logic none_cmd, inc_only;
    assign none_cmd = !(inc_en | jump_en | call_en | ret_en | tjmp_en | rtnw_en);
    assign inc_only = inc_en && !(jump_en | call_en | ret_en | tjmp_en | rtnw_en);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pc_out == '0 && tbr_out == '0 && !acc_we));

    assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
        inc_only |=> (pc_out[ADDR_W-2:0] == $past(pc_out[ADDR_W-2:0]) + 1'b1)
                     && (pc_out[ADDR_W-1] == $past(pc_out[ADDR_W-1])));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        ((jump_en | call_en) && !(ret_en | rtnw_en | tjmp_en)) |=> pc_out == $past(load_addr));

    assert_table_R5: assert property (@(posedge clk) disable iff (rst)
        (tjmp_en && !(ret_en | rtnw_en)) |=>
            pc_out == {$past(pc_out[ADDR_W-1:2*NIB_W]), $past(tbr_out), $past(acc_in)});

    assert_retk_R7: assert property (@(posedge clk) disable iff (rst)
        rtnw_en |=> (acc_we && acc_wdata == $past(rom_data[NIB_W-1:0])
                     && tbr_out == $past(rom_data[2*NIB_W-1:NIB_W])
                     && pc_out == $past(ret_addr)));

    assert_ret_prio_R8: assert property (@(posedge clk) disable iff (rst)
        (ret_en || rtnw_en) |=> pc_out == $past(ret_addr));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        none_cmd |=> ($stable(pc_out) && $stable(tbr_out)));

    assert_we_R10: assert property (@(posedge clk) disable iff (rst)
        !rtnw_en |=> !acc_we);
endmodule

bind pc_sequencer pcseq_checker #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_chk (
    .clk(clk), .rst(rst), .inc_en(inc_en), .jump_en(jump_en), .call_en(call_en),
    .ret_en(ret_en), .tjmp_en(tjmp_en), .rtnw_en(rtnw_en), .load_addr(load_addr),
    .ret_addr(ret_addr), .rom_data(rom_data), .acc_in(acc_in), .pc_out(pc_out),
    .tbr_out(tbr_out), .acc_we(acc_we), .acc_wdata(acc_wdata)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst, inc_en, jump_en, call_en, ret_en, tjmp_en, rtnw_en;
    logic [11:0] load_addr, ret_addr;
    logic [7:0]  rom_data;
    logic [3:0]  acc_in;
    logic [11:0] pc_out;
    logic [3:0]  tbr_out;
    logic        acc_we;
    logic [3:0]  acc_wdata;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_pc  = '0;
    logic [3:0]  m_tbr = '0;
    logic        m_we  = 1'b0;
    logic [3:0]  m_wd  = '0;

    always #10 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst(rst), .inc_en(inc_en), .jump_en(jump_en), .call_en(call_en),
        .ret_en(ret_en), .tjmp_en(tjmp_en), .rtnw_en(rtnw_en), .load_addr(load_addr),
        .ret_addr(ret_addr), .rom_data(rom_data), .acc_in(acc_in), .pc_out(pc_out),
        .tbr_out(tbr_out), .acc_we(acc_we), .acc_wdata(acc_wdata)
    );

    // Tag of the command that wins, ranked as in R8
    function automatic string win_tag();
        if (rst) return "R1";
        if (rtnw_en) return "R7";
        if (ret_en) return "R6";
        if (tjmp_en) return "R5";
        if (jump_en | call_en) return "R4";
        if (inc_en) return (m_pc[10:0] == 11'h7FF) ? "R3" : "R2";
        return "R9";
    endfunction

    task automatic model_step();
        m_we = 1'b0;
        m_wd = '0;
        if (rst) begin
            m_pc = '0; m_tbr = '0;
        end else if (rtnw_en) begin
            m_pc = ret_addr; m_tbr = rom_data[7:4]; m_we = 1'b1; m_wd = rom_data[3:0];
        end else if (ret_en) begin
            m_pc = ret_addr;
        end else if (tjmp_en) begin
            m_pc = {m_pc[11:8], m_tbr, acc_in};
        end else if (jump_en | call_en) begin
            m_pc = load_addr;
        end else if (inc_en) begin
            m_pc = {m_pc[11], m_pc[10:0] + 11'd1};
        end
    endtask

    task automatic idle();
        rst = 0; inc_en = 0; jump_en = 0; call_en = 0; ret_en = 0; tjmp_en = 0; rtnw_en = 0;
    endtask

    // Apply the inputs set for this cycle, clock once, compare
    task automatic cycle();
        string tag;
        tag = win_tag();
        model_step();
        @(posedge clk);
        #2;
        checks++;
        if (pc_out !== m_pc || tbr_out !== m_tbr || acc_we !== m_we || acc_wdata !== m_wd) begin
            errors++;
            $display("FAIL %s pc=%h tbr=%h we=%b wd=%h expected pc=%h tbr=%h we=%b wd=%h",
                     tag, pc_out, tbr_out, acc_we, acc_wdata, m_pc, m_tbr, m_we, m_wd);
        end
        if (tag == "R7" || (m_we == 1'b0 && acc_we !== 1'b0)) begin
            checks++; // R10 strobe only after return-constant
            if (acc_we !== m_we) begin
                errors++;
                $display("FAIL R10 we=%b expected %b", acc_we, m_we);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog pc=%h expected finish", pc_out);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        load_addr = '0; ret_addr = '0; rom_data = '0; acc_in = '0;
        @(negedge clk);
        rst = 1; inc_en = 1; jump_en = 1; load_addr = 12'hABC; cycle(); // R1
        idle(); cycle(); // R9
        inc_en = 1; cycle(); cycle(); // R2
        idle(); jump_en = 1; load_addr = 12'h7FE; cycle(); // R4
        idle(); inc_en = 1; cycle(); cycle(); // R3 0x7FF -> 0x000
        idle(); call_en = 1; load_addr = 12'hFFF; cycle(); // R4 page set
        idle(); inc_en = 1; cycle(); // R3 0xFFF -> 0x800
        idle(); rtnw_en = 1; ret_addr = 12'h9A5; rom_data = 8'h3C; cycle(); // R7
        idle(); cycle(); // R10 strobe drops
        tjmp_en = 1; acc_in = 4'h6; cycle(); // R5 -> 0x936
        idle(); ret_en = 1; ret_addr = 12'h1F0; cycle(); // R6 tbr kept
        idle(); ret_en = 1; tjmp_en = 1; jump_en = 1; inc_en = 1; ret_addr = 12'h455; cycle(); // R8
        idle(); tjmp_en = 1; jump_en = 1; acc_in = 4'hE; load_addr = 12'h111; cycle(); // R8
        idle(); rtnw_en = 1; ret_en = 1; rom_data = 8'hA5; ret_addr = 12'hC00; cycle(); // R8
        for (int i = 0; i < 600; i++) begin
            rst     = ($urandom % 40) == 0;
            inc_en  = ($urandom % 2) == 0;
            jump_en = ($urandom % 6) == 0;
            call_en = ($urandom % 8) == 0;
            ret_en  = ($urandom % 9) == 0;
            tjmp_en = ($urandom % 6) == 0;
            rtnw_en = ($urandom % 9) == 0;
            load_addr = 12'($urandom);
            ret_addr  = 12'($urandom);
            rom_data  = 8'($urandom);
            acc_in    = 4'($urandom);
            cycle();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule